// File: doc/BRIEF.md
# Exclusive Access Monitor

This block is the local reservation tracker for one master that issues load-exclusive and store-exclusive memory operations. A load-exclusive records a reservation, which is a valid flag, the effective address and the access size. A later store-exclusive is judged in the same cycle it is presented. It is allowed to write only if a reservation is held, and the reservation matches both its effective address and its access size, and no store touching the reserved bytes was observed in between. The block gives the memory system a write enable and gives the register file a one-bit status. Status 0 means the store was performed. Status 1 means it was refused.

The block also works out the effective address of each exclusive operation. That address is the base value alone, or the base plus an immediate offset. Only the word form may carry an offset, and the offset must be aligned and within range. An illegal encoding raises an error flag for that operation. It also makes the store fail, or stops the load from reserving.

Ordinary stores are reported on a parameterised number of observation channels. These include the master's own plain stores and stores by other agents. Any of them that overlaps the reserved bytes drops the reservation. A synchronous clear input, for example on exception entry, and reset also drop it. The block has no condition-flag outputs.

Top module: `excl_monitor`

## Requirements
- R1: Access sizes are coded on two bits: 0 is byte, 1 is halfword, 2 is word. Code 3 is reserved. An exclusive load or store that carries code 3 raises its error flag, and it neither reserves nor writes.
- R2: In the cycle a store-exclusive is presented, `st_wr_en` is 1 and `st_status` is 0 if the write is performed. Otherwise `st_wr_en` is 0 and `st_status` is 1. When no store-exclusive is presented, `st_wr_en` is 0.
- R3: A store-exclusive can succeed only if its effective address equals the effective address of the most recent load-exclusive that reserved.
- R4: A store-exclusive whose size code differs from the reserved size code fails.
- R5: Every store-exclusive, whether it passes or fails, drops the reservation. A store-exclusive presented with no reservation held fails.
- R6: An observed store on any channel, sized 1, 2 or 4 bytes by its size code, drops the reservation if any of its bytes overlap the reserved bytes. A store on adjacent bytes does not drop it.
- R7: `ld_eff_addr` and `st_eff_addr` equal the base plus the offset when an offset is present, and the base alone when it is not.
- R8: An offset is legal only on the word size, as a multiple of 4, from 0 to 1020. An illegal offset raises the operation's error flag. An illegal store fails, and an illegal load leaves no reservation.
- R9: A new load-exclusive replaces any earlier reservation. A store-exclusive in the same cycle as a load-exclusive is judged against the earlier reservation. A load-exclusive that coincides with an observed overlapping store still reserves.
- R10: Reset and the clear input drop the reservation. Clear takes priority over a load-exclusive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Drop the reservation at the next edge |
| ld_valid | input | 1 | Load-exclusive presented this cycle |
| ld_base | input | ADDR_W | Load base address |
| ld_off | input | OFF_W | Load immediate offset |
| ld_off_present | input | 1 | Load carries an offset |
| ld_size | input | 2 | Load size code |
| ld_eff_addr | output | ADDR_W | Load effective address |
| ld_err | output | 1 | Load encoding illegal |
| st_valid | input | 1 | Store-exclusive presented this cycle |
| st_base | input | ADDR_W | Store base address |
| st_off | input | OFF_W | Store immediate offset |
| st_off_present | input | 1 | Store carries an offset |
| st_size | input | 2 | Store size code |
| st_eff_addr | output | ADDR_W | Store effective address |
| st_err | output | 1 | Store encoding illegal |
| st_wr_en | output | 1 | Memory write permitted |
| st_status | output | 1 | Destination status, 0 pass, 1 fail |
| obs_valid | input | NUM_OBS | Observed ordinary store per channel |
| obs_addr | input | NUM_OBS*ADDR_W | Observed store addresses, channel 0 in the low bits |
| obs_size | input | NUM_OBS*2 | Observed store size codes |

## Verification
The bench builds the block with a 32-bit address, a 12-bit offset field, a 1020 limit on 4-byte alignment, two observation channels and exact byte-overlap matching. A 12-bit offset can express 1024 and values that are not multiples of four, so the out-of-range and misaligned cases are reachable. The two channels let both a local plain store and another agent's store hit the reservation. Exact overlap matching brings the boundary cases into reach: a store ending on the byte just below the reservation, and a byte store inside a halfword reservation.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

   typedef enum logic [1:0] {
      XSZ_BYTE = 2'd0,
      XSZ_HALF = 2'd1,
      XSZ_WORD = 2'd2,
      XSZ_RSVD = 2'd3
   } xsize_e;

   // number of bytes covered by an access of the given size code
   function automatic logic [3:0] size_bytes(input logic [1:0] code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/excl_addr_unit.sv
module excl_addr_unit
   import excl_mon_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 12,
   parameter int OFF_MAX   = 1020,
   parameter int OFF_ALIGN = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  off,
   input  logic              off_present,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              illegal
);

   localparam logic [OFF_W-1:0] ALIGN_MASK = OFF_W'(OFF_ALIGN - 1);
   localparam logic [OFF_W-1:0] LIMIT      = OFF_W'(OFF_MAX);

   logic is_word;
   logic misaligned;
   logic too_far;
   logic rsvd_size;

   always_comb begin
      is_word    = (xsize_e'(size) == XSZ_WORD);
      rsvd_size  = (xsize_e'(size) == XSZ_RSVD);
      misaligned = |(off & ALIGN_MASK);
      too_far    = (off > LIMIT);
      illegal    = rsvd_size | (off_present & (~is_word | misaligned | too_far));
      eff_addr   = base + (off_present ? ADDR_W'(off) : '0);
   end

endmodule

// File: rtl/excl_overlap.sv
module excl_overlap
   import excl_mon_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int GRAN_LG2 = 0
) (
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [1:0]        a_size,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [1:0]        b_size,
   output logic              hit
);

   generate
      if (GRAN_LG2 == 0) begin : g_exact
         logic [ADDR_W:0] a_lo, a_hi, b_lo, b_hi;
         always_comb begin
            a_lo = {1'b0, a_addr};
            b_lo = {1'b0, b_addr};
            a_hi = a_lo + (ADDR_W+1)'(size_bytes(a_size));
            b_hi = b_lo + (ADDR_W+1)'(size_bytes(b_size));
            hit  = (a_lo < b_hi) && (b_lo < a_hi);
         end
      end else begin : g_granule
         assign hit = (a_addr[ADDR_W-1:GRAN_LG2] == b_addr[ADDR_W-1:GRAN_LG2]);
      end
   endgenerate

endmodule

// File: rtl/excl_tag_store.sv
module excl_tag_store #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              set_req,
   input  logic              set_ok,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic [1:0]        set_size,
   input  logic              kill,
   output logic              tag_valid,
   output logic [ADDR_W-1:0] tag_addr,
   output logic [1:0]        tag_size
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_valid <= 1'b0;
         tag_addr  <= '0;
         tag_size  <= '0;
      end else if (clr) begin
         tag_valid <= 1'b0;
      end else if (set_req) begin
         tag_valid <= set_ok;
         tag_addr  <= set_addr;
         tag_size  <= set_size;
      end else if (kill) begin
         tag_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
   import excl_mon_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int OFF_W     = 12,
   parameter int OFF_MAX   = 1020,
   parameter int OFF_ALIGN = 4,
   parameter int NUM_OBS   = 2,
   parameter int GRAN_LG2  = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      ld_valid,
   input  logic [ADDR_W-1:0]         ld_base,
   input  logic [OFF_W-1:0]          ld_off,
   input  logic                      ld_off_present,
   input  logic [1:0]                ld_size,
   output logic [ADDR_W-1:0]         ld_eff_addr,
   output logic                      ld_err,
   input  logic                      st_valid,
   input  logic [ADDR_W-1:0]         st_base,
   input  logic [OFF_W-1:0]          st_off,
   input  logic                      st_off_present,
   input  logic [1:0]                st_size,
   output logic [ADDR_W-1:0]         st_eff_addr,
   output logic                      st_err,
   output logic                      st_wr_en,
   output logic                      st_status,
   input  logic [NUM_OBS-1:0]        obs_valid,
   input  logic [NUM_OBS*ADDR_W-1:0] obs_addr,
   input  logic [NUM_OBS*2-1:0]      obs_size
);

   // elaboration-time parameter checks
   generate
      if (OFF_ALIGN < 1 || (OFF_ALIGN & (OFF_ALIGN - 1)) != 0) begin : g_bad_align
         $error("OFF_ALIGN must be a power of two");
      end
      if (OFF_MAX % OFF_ALIGN != 0) begin : g_bad_max
         $error("OFF_MAX must be a multiple of OFF_ALIGN");
      end
      if (OFF_MAX >= (1 << OFF_W)) begin : g_bad_offw
         $error("OFF_W too narrow for OFF_MAX");
      end
      if (OFF_W >= ADDR_W) begin : g_bad_addrw
         $error("ADDR_W must exceed OFF_W");
      end
      if (NUM_OBS < 1) begin : g_bad_obs
         $error("NUM_OBS must be at least one");
      end
      if (GRAN_LG2 < 0 || GRAN_LG2 >= ADDR_W) begin : g_bad_gran
         $error("GRAN_LG2 out of range");
      end
   endgenerate

   logic              tag_valid;
   logic [ADDR_W-1:0] tag_addr;
   logic [1:0]        tag_size;
   logic [NUM_OBS-1:0] ov_hit;
   logic              obs_kill;
   logic              st_match;

   excl_addr_unit #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .OFF_MAX(OFF_MAX), .OFF_ALIGN(OFF_ALIGN)
   ) u_ld_addr (
      .base(ld_base), .off(ld_off), .off_present(ld_off_present), .size(ld_size),
      .eff_addr(ld_eff_addr), .illegal(ld_err)
   );

   excl_addr_unit #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .OFF_MAX(OFF_MAX), .OFF_ALIGN(OFF_ALIGN)
   ) u_st_addr (
      .base(st_base), .off(st_off), .off_present(st_off_present), .size(st_size),
      .eff_addr(st_eff_addr), .illegal(st_err)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_OBS; g++) begin : g_obs
         excl_overlap #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_ov (
            .a_addr(obs_addr[g*ADDR_W +: ADDR_W]),
            .a_size(obs_size[g*2 +: 2]),
            .b_addr(tag_addr),
            .b_size(tag_size),
            .hit   (ov_hit[g])
         );
      end
   endgenerate

   assign obs_kill = |(obs_valid & ov_hit);

   excl_tag_store #(.ADDR_W(ADDR_W)) u_tag (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .set_req(ld_valid), .set_ok(~ld_err),
      .set_addr(ld_eff_addr), .set_size(ld_size),
      .kill(st_valid | obs_kill),
      .tag_valid(tag_valid), .tag_addr(tag_addr), .tag_size(tag_size)
   );

   always_comb begin
      st_match  = tag_valid && (st_eff_addr == tag_addr) && (st_size == tag_size);
      st_wr_en  = st_valid && !st_err && st_match;
      st_status = !st_wr_en;
   end

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              ld_valid,
   input logic [ADDR_W-1:0] ld_base,
   input logic              ld_off_present,
   input logic [ADDR_W-1:0] ld_eff_addr,
   input logic              ld_err,
   input logic              st_valid,
   input logic              st_err,
   input logic              st_wr_en,
   input logic              st_status
);

   // R2
   wr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> (st_wr_en != st_status));

   // R2
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> !st_wr_en);

   // R5
   st_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !ld_valid) |=> !st_wr_en);

   // R8
   st_err_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_err |-> !st_wr_en);

   // R8
   ld_err_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_err) |=> !st_wr_en);

   // R10
   clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !st_wr_en);

   // R7
   ld_plain_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !ld_off_present) |-> (ld_eff_addr == ld_base));

endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .ld_valid(ld_valid), .ld_base(ld_base),
   .ld_off_present(ld_off_present), .ld_eff_addr(ld_eff_addr), .ld_err(ld_err),
   .st_valid(st_valid), .st_err(st_err), .st_wr_en(st_wr_en), .st_status(st_status)
);

// File: tb/excl_monitor_test.sv
module excl_monitor_test;

   localparam int AW = 32;
   localparam int OW = 12;
   localparam int NO = 2;

   localparam logic [2:0] OP_IDLE = 3'd0, OP_LD = 3'd1, OP_ST = 3'd2,
                          OP_OBS = 3'd3, OP_SNP = 3'd4, OP_CLR = 3'd5;

   typedef struct packed {
      logic [3:0]    req;
      logic [2:0]    op;
      logic [AW-1:0] base;
      logic          offp;
      logic [OW-1:0] off;
      logic [1:0]    size;
      logic [AW-1:0] eaddr;
      logic          ewr;
      logic          eerr;
   } vec_t;

   localparam int NV = 40;
   localparam vec_t VECS [NV] = '{
      '{4'd5,  OP_ST,  32'h100, 1'b0, 12'd0,    2'd2, 32'h100, 1'b0, 1'b0}, // R5 no reservation
      '{4'd2,  OP_LD,  32'h100, 1'b0, 12'd0,    2'd2, 32'h100, 1'b0, 1'b0},
      '{4'd2,  OP_ST,  32'h100, 1'b0, 12'd0,    2'd2, 32'h100, 1'b1, 1'b0}, // R2 pass
      '{4'd5,  OP_ST,  32'h100, 1'b0, 12'd0,    2'd2, 32'h100, 1'b0, 1'b0}, // R5 consumed
      '{4'd7,  OP_LD,  32'h200, 1'b1, 12'd8,    2'd2, 32'h208, 1'b0, 1'b0}, // R7
      '{4'd3,  OP_ST,  32'h200, 1'b1, 12'd8,    2'd2, 32'h208, 1'b1, 1'b0}, // R3 R7
      '{4'd4,  OP_LD,  32'h300, 1'b0, 12'd0,    2'd1, 32'h300, 1'b0, 1'b0},
      '{4'd4,  OP_ST,  32'h300, 1'b0, 12'd0,    2'd0, 32'h300, 1'b0, 1'b0}, // R4 size mismatch
      '{4'd3,  OP_LD,  32'h300, 1'b0, 12'd0,    2'd1, 32'h300, 1'b0, 1'b0},
      '{4'd3,  OP_ST,  32'h302, 1'b0, 12'd0,    2'd1, 32'h302, 1'b0, 1'b0}, // R3 addr mismatch
      '{4'd6,  OP_LD,  32'h400, 1'b0, 12'd0,    2'd2, 32'h400, 1'b0, 1'b0},
      '{4'd6,  OP_SNP, 32'h402, 1'b0, 12'd0,    2'd0, 32'h0,   1'b0, 1'b0},
      '{4'd6,  OP_ST,  32'h400, 1'b0, 12'd0,    2'd2, 32'h400, 1'b0, 1'b0}, // R6 snooped
      '{4'd6,  OP_LD,  32'h400, 1'b0, 12'd0,    2'd2, 32'h400, 1'b0, 1'b0},
      '{4'd6,  OP_OBS, 32'h404, 1'b0, 12'd0,    2'd2, 32'h0,   1'b0, 1'b0},
      '{4'd6,  OP_ST,  32'h400, 1'b0, 12'd0,    2'd2, 32'h400, 1'b1, 1'b0}, // R6 adjacent above
      '{4'd9,  OP_LD,  32'h500, 1'b0, 12'd0,    2'd0, 32'h500, 1'b0, 1'b0},
      '{4'd9,  OP_LD,  32'h600, 1'b0, 12'd0,    2'd0, 32'h600, 1'b0, 1'b0},
      '{4'd9,  OP_ST,  32'h500, 1'b0, 12'd0,    2'd0, 32'h500, 1'b0, 1'b0}, // R9 replaced
      '{4'd10, OP_LD,  32'h600, 1'b0, 12'd0,    2'd0, 32'h600, 1'b0, 1'b0},
      '{4'd10, OP_CLR, 32'h0,   1'b0, 12'd0,    2'd0, 32'h0,   1'b0, 1'b0},
      '{4'd10, OP_ST,  32'h600, 1'b0, 12'd0,    2'd0, 32'h600, 1'b0, 1'b0}, // R10 cleared
      '{4'd8,  OP_LD,  32'h700, 1'b0, 12'd0,    2'd2, 32'h700, 1'b0, 1'b0},
      '{4'd8,  OP_ST,  32'h700, 1'b1, 12'd6,    2'd2, 32'h706, 1'b0, 1'b1}, // R8 misaligned
      '{4'd8,  OP_LD,  32'h800, 1'b1, 12'd1024, 2'd2, 32'hC00, 1'b0, 1'b1}, // R8 too far
      '{4'd8,  OP_ST,  32'hC00, 1'b0, 12'd0,    2'd2, 32'hC00, 1'b0, 1'b0}, // R8 no reservation
      '{4'd8,  OP_LD,  32'h900, 1'b1, 12'd4,    2'd1, 32'h904, 1'b0, 1'b1}, // R8 offset on half
      '{4'd8,  OP_LD,  32'hA00, 1'b1, 12'd1020, 2'd2, 32'hDFC, 1'b0, 1'b0}, // R8 limit
      '{4'd8,  OP_ST,  32'hA00, 1'b1, 12'd1020, 2'd2, 32'hDFC, 1'b1, 1'b0}, // R8 limit pass
      '{4'd6,  OP_LD,  32'hB00, 1'b0, 12'd0,    2'd2, 32'hB00, 1'b0, 1'b0},
      '{4'd6,  OP_OBS, 32'hAFC, 1'b0, 12'd0,    2'd2, 32'h0,   1'b0, 1'b0},
      '{4'd6,  OP_ST,  32'hB00, 1'b0, 12'd0,    2'd2, 32'hB00, 1'b1, 1'b0}, // R6 adjacent below
      '{4'd1,  OP_LD,  32'h1000,1'b0, 12'd0,    2'd3, 32'h1000,1'b0, 1'b1}, // R1 reserved size
      '{4'd1,  OP_ST,  32'h1000,1'b0, 12'd0,    2'd3, 32'h1000,1'b0, 1'b1}, // R1 reserved size
      '{4'd6,  OP_LD,  32'h1100,1'b0, 12'd0,    2'd1, 32'h1100,1'b0, 1'b0},
      '{4'd6,  OP_OBS, 32'h1101,1'b0, 12'd0,    2'd0, 32'h0,   1'b0, 1'b0},
      '{4'd6,  OP_ST,  32'h1100,1'b0, 12'd0,    2'd1, 32'h1100,1'b0, 1'b0}, // R6 byte inside half
      '{4'd6,  OP_LD,  32'h1200,1'b0, 12'd0,    2'd0, 32'h1200,1'b0, 1'b0},
      '{4'd6,  OP_SNP, 32'h11FC,1'b0, 12'd0,    2'd2, 32'h0,   1'b0, 1'b0},
      '{4'd6,  OP_ST,  32'h1200,1'b0, 12'd0,    2'd0, 32'h1200,1'b1, 1'b0}  // R6 word below byte
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              clr;
   logic              ld_valid, ld_off_present, st_valid, st_off_present;
   logic [AW-1:0]     ld_base, st_base, ld_eff_addr, st_eff_addr;
   logic [OW-1:0]     ld_off, st_off;
   logic [1:0]        ld_size, st_size;
   logic              ld_err, st_err, st_wr_en, st_status;
   logic [NO-1:0]     obs_valid;
   logic [NO*AW-1:0]  obs_addr;
   logic [NO*2-1:0]   obs_size;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   excl_monitor #(
      .ADDR_W(AW), .OFF_W(OW), .OFF_MAX(1020), .OFF_ALIGN(4), .NUM_OBS(NO), .GRAN_LG2(0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ld_valid(ld_valid), .ld_base(ld_base), .ld_off(ld_off),
      .ld_off_present(ld_off_present), .ld_size(ld_size),
      .ld_eff_addr(ld_eff_addr), .ld_err(ld_err),
      .st_valid(st_valid), .st_base(st_base), .st_off(st_off),
      .st_off_present(st_off_present), .st_size(st_size),
      .st_eff_addr(st_eff_addr), .st_err(st_err),
      .st_wr_en(st_wr_en), .st_status(st_status),
      .obs_valid(obs_valid), .obs_addr(obs_addr), .obs_size(obs_size)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      clr = 1'b0;
      ld_valid = 1'b0; ld_base = '0; ld_off = '0; ld_off_present = 1'b0; ld_size = 2'd2;
      st_valid = 1'b0; st_base = '0; st_off = '0; st_off_present = 1'b0; st_size = 2'd2;
      obs_valid = '0; obs_addr = '0; obs_size = '0;
   endtask

   task automatic set_ld(input logic [31:0] b, input logic [1:0] s);
      ld_valid = 1'b1; ld_base = b; ld_size = s; ld_off_present = 1'b0; ld_off = '0;
   endtask

   task automatic set_st(input logic [31:0] b, input logic [1:0] s);
      st_valid = 1'b1; st_base = b; st_size = s; st_off_present = 1'b0; st_off = '0;
   endtask

   initial begin
      rst_n = 1'b0;
      idle_inputs();
      // R10 reset state: a store-exclusive during reset is refused
      @(negedge clk);
      set_st(32'h100, 2'd2);
      #2;
      chk("R10", "wr_en in reset", 32'(st_wr_en), 32'd0);
      chk("R10", "status in reset", 32'(st_status), 32'd1);
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         idle_inputs();
         case (VECS[i].op)
            OP_LD: begin
               ld_valid = 1'b1; ld_base = VECS[i].base; ld_off = VECS[i].off;
               ld_off_present = VECS[i].offp; ld_size = VECS[i].size;
            end
            OP_ST: begin
               st_valid = 1'b1; st_base = VECS[i].base; st_off = VECS[i].off;
               st_off_present = VECS[i].offp; st_size = VECS[i].size;
            end
            OP_OBS: begin
               obs_valid[0] = 1'b1; obs_addr[0 +: AW] = VECS[i].base;
               obs_size[0 +: 2] = VECS[i].size;
            end
            OP_SNP: begin
               obs_valid[1] = 1'b1; obs_addr[AW +: AW] = VECS[i].base;
               obs_size[2 +: 2] = VECS[i].size;
            end
            OP_CLR: clr = 1'b1;
            default: ;
         endcase
         #2;
         case (VECS[i].op)
            OP_LD: begin
               chk($sformatf("R%0d row %0d", VECS[i].req, i), "ld_err", 32'(ld_err), 32'(VECS[i].eerr));
               chk($sformatf("R%0d row %0d", VECS[i].req, i), "ld_eff_addr", ld_eff_addr, VECS[i].eaddr);
            end
            OP_ST: begin
               chk($sformatf("R%0d row %0d", VECS[i].req, i), "st_wr_en", 32'(st_wr_en), 32'(VECS[i].ewr));
               chk($sformatf("R%0d row %0d", VECS[i].req, i), "st_status", 32'(st_status), 32'(!VECS[i].ewr));
               chk($sformatf("R%0d row %0d", VECS[i].req, i), "st_err", 32'(st_err), 32'(VECS[i].eerr));
               chk($sformatf("R%0d row %0d", VECS[i].req, i), "st_eff_addr", st_eff_addr, VECS[i].eaddr);
            end
            default:
               chk("R2", "wr_en idle", 32'(st_wr_en), 32'd0);
         endcase
      end

      // R10: reset drops a held reservation
      @(negedge clk); idle_inputs(); set_ld(32'hF00, 2'd2);
      @(negedge clk); idle_inputs(); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; set_st(32'hF00, 2'd2);
      #2 chk("R10", "st after reset", 32'(st_wr_en), 32'd0);

      // R9: store judged on old reservation while a load reserves anew
      @(negedge clk); idle_inputs(); set_ld(32'hD00, 2'd2);
      @(negedge clk); idle_inputs(); set_st(32'hD00, 2'd2); set_ld(32'hE00, 2'd2);
      #2 chk("R9", "st with concurrent ld", 32'(st_wr_en), 32'd1);
      @(negedge clk); idle_inputs(); set_st(32'hE00, 2'd2);
      #2 chk("R9", "st on new reservation", 32'(st_wr_en), 32'd1);

      // R9: load wins over an overlapping observed store in the same cycle
      @(negedge clk); idle_inputs(); set_ld(32'h1300, 2'd2);
      obs_valid[1] = 1'b1; obs_addr[AW +: AW] = 32'h1300; obs_size[2 +: 2] = 2'd2;
      @(negedge clk); idle_inputs(); set_st(32'h1300, 2'd2);
      #2 chk("R9", "ld beats snoop", 32'(st_wr_en), 32'd1);

      // R10: clear beats a same-cycle load
      @(negedge clk); idle_inputs(); set_ld(32'h1400, 2'd2); clr = 1'b1;
      @(negedge clk); idle_inputs(); set_st(32'h1400, 2'd2);
      #2 chk("R10", "clr beats ld", 32'(st_wr_en), 32'd0);
      chk("R10", "clr beats ld status", 32'(st_status), 32'd1);

      @(negedge clk); idle_inputs();
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule